// File: doc/BRIEF.md
# Debug Arm and Breakpoint Dispatch Controller

This block is the control and sequencing core of an on-chip debug unit. A host writes one 8-bit control register over a simple register bus. That register holds an arm bit, an immediate-trigger bit, a two-bit breakpoint-target field, a CPU-routing select, a coprocessor software-breakpoint enable and a two-bit comparator bank select. Arming the unit starts a three-state sequencer: idle, then a first armed state, then a final state. The final state is reached when a comparator reports a hit or when software forces a trigger. Once the sequencer is final, the unit either asks for breakpoints straight away or hands over to a trace-session controller and waits for that session to end.

Comparator matching and the trace store lie outside the block and appear only as strobes. Its results are single-cycle breakpoint pulses to the main CPU and to a coprocessor. It also drives a one-hot selector that names the comparator register bank and state-control register shown in the host's register window.

Top module: `dbg_seq_ctrl`

## Requirements
- R1: After reset every control bit reads 0, `seq_state` is 2'b00 (idle), every pulse output is low and `bank_sel` is 4'b0001.
- R2: Control layout: bit0 arm, bit1 trigger, bits3:2 target, bit4 CPU routing, bit5 coprocessor-request enable, bits7:6 bank. A write while disarmed stores every field. The trigger bit always reads 0. `bank_sel` is one-hot with bit N set for bank N.
- R3: A write that takes arm from 0 to 1 puts `seq_state` at 2'b01 after the write edge. A write of arm 0 while armed returns to idle (2'b00) at any time and abandons any running trace.
- R4: While arm reads 1, a write changes only the arm bit and may request a trigger. Bits 7:2 keep their values.
- R5: A write whose trigger bit is 1 and whose arm bit is 1 moves the sequencer to the final state (2'b11) after that edge. This holds for the write that sets arm as well. A trigger bit of 0 changes nothing.
- R6: A trigger write is ignored while `secure` is high, and also while a trace started with begin or mid alignment (`align_end`=0) is running.
- R7: In state 2'b01 a `final_hit` strobe moves the sequencer to 2'b11 after that edge.
- R8: Tracing is off when `trace_src` is 00 or `secure` is high. In that case the breakpoints fire one cycle after the final state is reached, and in the same cycle arm clears and the state returns to idle.
- R9: With tracing on, `trace_start` pulses one cycle after the arming write for begin/mid alignment, or one cycle after the final state is reached for end alignment. When the session ends (`trace_done` or `trace_full` sampled while running) arm clears and the state goes idle. Breakpoints fire in that same cycle only if the state was final.
- R10: Target field: 00 gives no breakpoint, 01 coprocessor only (`cop_bp`), 10 CPU only, 11 both.
- R11: A CPU breakpoint goes to `cpu_bp_dbg` when bit4 is 1 and to `cpu_bp_swi` when bit4 is 0. It never drives both.
- R12: A `cop_swbp_req` strobe gives a CPU breakpoint one cycle later only when bit5 is 1.
- R13: Breakpoint outputs are single-cycle pulses for a single-cycle cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register read value |
| secure | input | 1 | Secure mode: tracing and trigger writes disabled |
| trace_src | input | 2 | Trace source select; 00 disables tracing |
| align_end | input | 1 | 1 = trace aligned to the end of the trigger, 0 = begin/mid |
| final_hit | input | 1 | Comparator strobe toward the final state |
| cop_swbp_req | input | 1 | Coprocessor software-breakpoint request |
| trace_done | input | 1 | Trace session completed |
| trace_full | input | 1 | Trace store full, ends session |
| seq_state | output | 2 | Sequencer state: 00 idle, 01 armed, 11 final |
| trace_start | output | 1 | One-cycle trace session start |
| cpu_bp_dbg | output | 1 | CPU breakpoint to debug-mode entry |
| cpu_bp_swi | output | 1 | CPU breakpoint as software interrupt |
| cop_bp | output | 1 | Coprocessor breakpoint |
| bank_sel | output | 4 | One-hot comparator bank / state-control register select |

## Verification
Register fields, the sequencer state and `bank_sel` update on the edge that samples a write or strobe, so the bench reads them at the falling edge right after. A breakpoint with tracing off appears one edge after the final state is reached. A breakpoint at the end of a session, a forwarded coprocessor request and `trace_start` each appear on the edge that samples their cause. The bench drives every input at a falling edge and checks exactly one falling edge later per registered step. It then checks one more cycle to confirm that each pulse has dropped.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int REG_W     = 8;
    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'b00,
        SEQ_ARMED = 2'b01,
        SEQ_FINAL = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              cop_sw_en;
        logic              dbg_mode;
        logic [1:0]        bp_tgt;
        logic              trig;
        logic              arm;
    } ctrl_t;

    // Armed register keeps everything except arm; trigger never stored as 1.
    function automatic ctrl_t apply_write(ctrl_t cur, ctrl_t wr);
        ctrl_t r;
        if (cur.arm) begin
            r     = cur;
            r.arm = wr.arm;
        end else begin
            r = wr;
        end
        r.trig = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    input  logic  hw_disarm,
    output ctrl_t cur,
    output logic  arm_set,
    output logic  arm_clr,
    output logic  trig_req
);
    ctrl_t nxt;

    always_comb begin
        nxt = cur;
        if (wr_en)     nxt = apply_write(cur, wr_val);
        if (hw_disarm) nxt.arm = 1'b0;
    end

    assign arm_set  = wr_en && !cur.arm && wr_val.arm;
    assign arm_clr  = wr_en &&  cur.arm && !wr_val.arm;
    assign trig_req = wr_en &&  wr_val.trig && wr_val.arm;

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/dbg_sequencer.sv
module dbg_sequencer
    import dbg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_set,
    input  logic       arm_clr,
    input  logic       trig_req,
    input  logic       secure,
    input  logic       trace_en,
    input  logic       align_end,
    input  logic       final_hit,
    input  logic       trace_done,
    input  logic       trace_full,
    output seq_state_e state,
    output logic       trace_start,
    output logic       fire,
    output logic       hw_disarm
);
    logic running;
    logic trig_ok;
    logic sess_end;
    logic direct_bp;

    assign trig_ok   = !secure && !(running && !align_end);
    assign sess_end  = running && (trace_done || trace_full);
    assign direct_bp = (state == SEQ_FINAL) && !running && !trace_en;
    assign fire      = direct_bp || (sess_end && state == SEQ_FINAL);
    assign hw_disarm = direct_bp || sess_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            running     <= 1'b0;
            trace_start <= 1'b0;
        end else begin
            trace_start <= 1'b0;
            if (arm_clr || hw_disarm) begin
                state   <= SEQ_IDLE;
                running <= 1'b0;
            end else if (arm_set) begin
                state <= (trig_req && trig_ok) ? SEQ_FINAL : SEQ_ARMED;
                if (trace_en && !align_end) begin
                    running     <= 1'b1;
                    trace_start <= 1'b1;
                end
            end else if (state != SEQ_IDLE && trig_req && trig_ok) begin
                state <= SEQ_FINAL;
            end else if (state == SEQ_ARMED && final_hit) begin
                state <= SEQ_FINAL;
            end else if (state == SEQ_FINAL && !running && trace_en) begin
                running     <= 1'b1;
                trace_start <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_bp_dispatch.sv
module dbg_bp_dispatch
    import dbg_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  ctrl_t cfg,
    input  logic cop_swbp_req,
    output logic cpu_bp_dbg,
    output logic cpu_bp_swi,
    output logic cop_bp
);
    logic cpu_evt;

    assign cpu_evt = (fire && cfg.bp_tgt[1]) || (cop_swbp_req && cfg.cop_sw_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_bp_dbg <= 1'b0;
            cpu_bp_swi <= 1'b0;
            cop_bp     <= 1'b0;
        end else begin
            cpu_bp_dbg <= cpu_evt &&  cfg.dbg_mode;
            cpu_bp_swi <= cpu_evt && !cfg.dbg_mode;
            cop_bp     <= fire && cfg.bp_tgt[0];
        end
    end
endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
    import dbg_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 secure,
    input  logic [1:0]           trace_src,
    input  logic                 align_end,
    input  logic                 final_hit,
    input  logic                 cop_swbp_req,
    input  logic                 trace_done,
    input  logic                 trace_full,
    output logic [1:0]           seq_state,
    output logic                 trace_start,
    output logic                 cpu_bp_dbg,
    output logic                 cpu_bp_swi,
    output logic                 cop_bp,
    output logic [NUM_BANKS-1:0] bank_sel
);
    ctrl_t      ctrl;
    seq_state_e st;
    logic       arm_set, arm_clr, trig_req;
    logic       fire, hw_disarm;
    logic       trace_en;

    assign trace_en = (|trace_src) && !secure;

    dbg_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_val   (ctrl_t'(wr_data)),
        .hw_disarm(hw_disarm),
        .cur      (ctrl),
        .arm_set  (arm_set),
        .arm_clr  (arm_clr),
        .trig_req (trig_req)
    );

    dbg_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm_set    (arm_set),
        .arm_clr    (arm_clr),
        .trig_req   (trig_req),
        .secure     (secure),
        .trace_en   (trace_en),
        .align_end  (align_end),
        .final_hit  (final_hit),
        .trace_done (trace_done),
        .trace_full (trace_full),
        .state      (st),
        .trace_start(trace_start),
        .fire       (fire),
        .hw_disarm  (hw_disarm)
    );

    dbg_bp_dispatch u_bp (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .cfg         (ctrl),
        .cop_swbp_req(cop_swbp_req),
        .cpu_bp_dbg  (cpu_bp_dbg),
        .cpu_bp_swi  (cpu_bp_swi),
        .cop_bp      (cop_bp)
    );

    assign rd_data   = REG_W'(ctrl);
    assign seq_state = st;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_sel[b] = (ctrl.bank == BANK_W'(b));
    end
endmodule

// File: rtl/dbg_seq_ctrl_chk.sv
module dbg_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_arm,
    input logic       wr_trig,
    input logic       secure,
    input logic       final_hit,
    input logic [7:0] rd_data,
    input logic [1:0] seq_state,
    input logic       trace_start,
    input logic       cpu_bp_dbg,
    input logic       cpu_bp_swi,
    input logic       cop_bp
);
    // R2: trigger bit never reads back as 1
    a_r2_trig_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_data[1]);

    // R3: sequencer idle exactly when disarmed
    a_r3_idle_iff_disarmed: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'b00) == !rd_data[0]);

    // R4: armed write leaves upper fields untouched
    a_r4_locked_fields: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_data[0]) |=> (rd_data[7:2] == $past(rd_data[7:2])));

    // R6: secure trigger write cannot reach final state
    a_r6_secure_trig: assert property (@(posedge clk) disable iff (rst)
        (secure && wr_en && wr_arm && wr_trig && !final_hit && seq_state != 2'b11)
        |=> (seq_state != 2'b11));

    // R8: breakpoint toward coprocessor coincides with disarm
    a_r8_bp_disarms: assert property (@(posedge clk) disable iff (rst)
        cop_bp |-> !rd_data[0]);

    // R10: coprocessor pulse only when target bit0 was set
    a_r10_cop_target: assert property (@(posedge clk) disable iff (rst)
        cop_bp |-> $past(rd_data[2]));

    // R11: CPU routing outputs mutually exclusive
    a_r11_route_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_bp_dbg, cpu_bp_swi}));

    // R9: a trace session only starts while armed
    a_r9_start_armed: assert property (@(posedge clk) disable iff (rst)
        trace_start |-> (seq_state != 2'b00));
endmodule

bind dbg_seq_ctrl dbg_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_arm     (wr_data[0]),
    .wr_trig    (wr_data[1]),
    .secure     (secure),
    .final_hit  (final_hit),
    .rd_data    (rd_data),
    .seq_state  (seq_state),
    .trace_start(trace_start),
    .cpu_bp_dbg (cpu_bp_dbg),
    .cpu_bp_swi (cpu_bp_swi),
    .cop_bp     (cop_bp)
);

// File: tb/dbg_seq_ctrl_test.sv
module dbg_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       secure = 1'b0;
    logic [1:0] trace_src = 2'b00;
    logic       align_end = 1'b0;
    logic       final_hit = 1'b0;
    logic       cop_swbp_req = 1'b0;
    logic       trace_done = 1'b0;
    logic       trace_full = 1'b0;
    logic [1:0] seq_state;
    logic       trace_start, cpu_bp_dbg, cpu_bp_swi, cop_bp;
    logic [3:0] bank_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbg_seq_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .secure(secure), .trace_src(trace_src), .align_end(align_end),
        .final_hit(final_hit), .cop_swbp_req(cop_swbp_req),
        .trace_done(trace_done), .trace_full(trace_full),
        .seq_state(seq_state), .trace_start(trace_start),
        .cpu_bp_dbg(cpu_bp_dbg), .cpu_bp_swi(cpu_bp_swi), .cop_bp(cop_bp),
        .bank_sel(bank_sel)
    );

    // {write value, expected read value}, all with arm = 0
    localparam logic [15:0] VEC [6] = '{
        16'h9C9C, 16'h6260, 16'hF2F0, 16'h2E2C, 16'h4040, 16'h0000
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // 0 hit, 1 done, 2 full, 3 coprocessor request
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: final_hit = 1'b1;
            1: trace_done = 1'b1;
            2: trace_full = 1'b1;
            default: cop_swbp_req = 1'b1;
        endcase
        @(negedge clk);
        final_hit = 1'b0; trace_done = 1'b0; trace_full = 1'b0; cop_swbp_req = 1'b0;
    endtask

    task automatic chk_bp(input string tag, input int d, input int s, input int c);
        chk({tag, " cpu_bp_dbg"}, int'(cpu_bp_dbg), d);
        chk({tag, " cpu_bp_swi"}, int'(cpu_bp_swi), s);
        chk({tag, " cop_bp"},     int'(cop_bp), c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 seq_state", int'(seq_state), 0);
        chk("R1 bank_sel", int'(bank_sel), 1);
        chk("R1 trace_start", int'(trace_start), 0);
        chk_bp("R1", 0, 0, 0);

        // R2 register layout while disarmed
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][15:8]);
            chk("R2 readback", int'(rd_data), int'(VEC[i][7:0]));
            chk("R2 bank_sel", int'(bank_sel), 1 << VEC[i][15:14]);
            chk("R2 stays idle", int'(seq_state), 0);
        end

        // R3/R4/R7/R8/R10/R11/R13 comparator path, no tracing
        wr(8'h9C);
        wr(8'h9D);
        chk("R3 armed state", int'(seq_state), 1);
        chk("R3 armed read", int'(rd_data), 8'h9D);
        wr(8'h41);
        chk("R4 locked read", int'(rd_data), 8'h9D);
        chk("R4 locked bank", int'(bank_sel), 4'b0100);
        strobe(0);
        chk("R7 final state", int'(seq_state), 3);
        chk_bp("R8 not yet", 0, 0, 0);
        tick();
        chk_bp("R8 R10 R11 both dbg", 1, 0, 1);
        chk("R8 idle", int'(seq_state), 0);
        chk("R8 arm cleared", int'(rd_data), 8'h9C);
        tick();
        chk_bp("R13 pulse drop", 0, 0, 0);

        // R5 trigger, CPU-only target to software interrupt
        wr(8'h08);
        wr(8'h09);
        wr(8'h01);
        chk("R5 trig0 no effect", int'(seq_state), 1);
        chk("R5 trig0 read", int'(rd_data), 8'h09);
        wr(8'h03);
        chk("R5 trig final", int'(seq_state), 3);
        tick();
        chk_bp("R10 R11 cpu swi", 0, 1, 0);
        chk("R5 read after", int'(rd_data), 8'h08);
        // R3 software disarm
        wr(8'h09);
        wr(8'h00);
        chk("R3 disarm state", int'(seq_state), 0);
        chk("R3 disarm read", int'(rd_data), 8'h08);

        // R6 secure blocks trigger
        secure = 1'b1;
        wr(8'h09);
        wr(8'h0B);
        chk("R6 secure trig", int'(seq_state), 1);
        wr(8'h08);
        secure = 1'b0;

        // R10 target none, arm+trigger in one write (R5)
        wr(8'h00);
        wr(8'h03);
        chk("R5 arm+trig final", int'(seq_state), 3);
        tick();
        chk_bp("R10 none", 0, 0, 0);
        chk("R8 none idle", int'(seq_state), 0);

        // R9 end-aligned trace
        trace_src = 2'b01; align_end = 1'b1;
        wr(8'h04);
        wr(8'h05);
        chk("R9 end no early start", int'(trace_start), 0);
        wr(8'h07);
        chk("R9 end final", int'(seq_state), 3);
        tick();
        chk("R9 end start", int'(trace_start), 1);
        chk_bp("R9 wait", 0, 0, 0);
        tick();
        chk("R9 start pulse", int'(trace_start), 0);
        chk("R9 holds final", int'(seq_state), 3);
        strobe(1);
        chk_bp("R9 done bp", 0, 0, 1);
        chk("R9 done idle", int'(seq_state), 0);
        chk("R9 done read", int'(rd_data), 8'h04);

        // R9/R6 begin-aligned trace
        align_end = 1'b0;
        wr(8'h05);
        chk("R9 begin start", int'(trace_start), 1);
        chk("R9 begin armed", int'(seq_state), 1);
        wr(8'h07);
        chk("R6 trig ignored running", int'(seq_state), 1);
        strobe(0);
        chk("R7 begin final", int'(seq_state), 3);
        tick();
        chk_bp("R9 begin waits", 0, 0, 0);
        strobe(2);
        chk_bp("R9 full bp", 0, 0, 1);
        chk("R9 full idle", int'(seq_state), 0);

        // R9 session ends before final state: no breakpoint
        wr(8'h05);
        strobe(1);
        chk_bp("R9 early end", 0, 0, 0);
        chk("R9 early idle", int'(seq_state), 0);
        chk("R9 early read", int'(rd_data), 8'h04);
        trace_src = 2'b00;

        // R12 coprocessor software request
        wr(8'h30);
        strobe(3);
        chk_bp("R12 enabled", 1, 0, 0);
        tick();
        chk_bp("R13 req drop", 0, 0, 0);
        wr(8'h10);
        strobe(3);
        chk_bp("R12 disabled", 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule